// File: doc/BRIEF.md
# Split Execute Stage with Run-Time Transparent Mid Register

This block is the execute section of an in-order pipeline. It is cut into two half-stages with a staging register between them. The staging register can either clock normally or pass its inputs straight through. A mode pin chooses between the two behaviours. In fast mode the register clocks, so a long operation uses one half per cycle. It finishes two cycles after issue and never holds back the operations behind it. A short operation needs only the first half, so it goes straight to the result register when nothing is staged. In low-power mode the staging register is transparent, the two halves form a single stage, and every operation finishes in one cycle.

The long operation is a W-bit addition. The first half adds the low halves and stages the carry. The second half adds the high halves with that carry. Short operations are bitwise logic. Results always leave in issue order. A short operation issued while something is staged also goes through the staging register. This costs it one cycle but never stalls issue. A mode request takes effect only once nothing is staged. The input stream is back-pressured for exactly that time.

Back-pressure rules: `in_ready` is low while `lp_mode_i` differs from the active mode. An offered operation must hold its fields and `in_valid` until a cycle with `in_ready` high. The result side has no ready signal: the consumer takes every cycle in which `out_valid` is high. At most one result is produced per cycle.

Top module: `sx_split_exec`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` is 0 and, with `lp_mode_i` at 0, `in_ready` is 1; the active mode after reset is fast mode.
- R2: A short operation (`in_long`=0) returns `in_func` 0: A AND B, 1: A OR B, 2: A XOR B, 3: A AND NOT B.
- R3: A long operation (`in_long`=1) returns (A + B) modulo 2^W, with the carry from the low half entering the high half.
- R4: In fast mode (`lp_mode_i`=0) a long operation produces its result two cycles after acceptance, and long operations accepted back to back are never stalled (`in_ready` stays 1).
- R5: In fast mode a short operation accepted while nothing is staged produces its result one cycle after acceptance.
- R6: In fast mode a short operation accepted while an operation is staged produces its result two cycles after acceptance, after the earlier result, without stalling issue.
- R7: In low-power mode (`lp_mode_i`=1) every operation, long or short, produces its result one cycle after acceptance.
- R8: When `lp_mode_i` differs from the active mode, `in_ready` is 0 until nothing is staged. The mode then switches, and the first operation accepted afterwards follows the new mode's timing.
- R9: An operation offered while `in_ready` is 0 and withdrawn before `in_ready` rises produces no result.
- R10: Every accepted operation produces exactly one `out_valid` cycle, results appear in acceptance order, and no result appears without a prior acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_mode_i | input | 1 | Requested mode: 1 low-power, 0 fast |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when high together with in_valid |
| in_long | input | 1 | 1: long (add) class, 0: short (logic) class |
| in_func | input | 2 | Short operation select (see R2) |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | W | Result value |

## Verification
The hardest state to reach from the ports is a short operation arriving in fast mode while a long one sits in the staging register. It is harder still when a chain of shorts follows, each held in the staging register in turn, and a mode request arrives while an operation is still staged. The stimulus issues operations back to back with no idle cycles, first from a mixed table and then in directed bursts. The per-operation latency is computed from the acceptance and result cycles. A mode request is raised in the cycle right after a long issue, so the switch must wait for the staged operation to drain.

// File: rtl/sx_pkg.sv
package sx_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'd0,
    FN_OR   = 2'd1,
    FN_XOR  = 2'd2,
    FN_ANDN = 2'd3
  } fn_e;
endpackage

// File: rtl/sx_logic_unit.sv
module sx_logic_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  sx_pkg::fn_e   fn,
  output logic [W-1:0]  y
);
  always_comb begin
    unique case (fn)
      sx_pkg::FN_AND:  y = a & b;
      sx_pkg::FN_OR:   y = a | b;
      sx_pkg::FN_XOR:  y = a ^ b;
      default:         y = a & ~b;
    endcase
  end
endmodule

// File: rtl/sx_add_half.sv
module sx_add_half #(
  parameter int IW = 8,
  parameter int OW = 9
) (
  input  logic [IW-1:0] a,
  input  logic [IW-1:0] b,
  input  logic          cin,
  output logic [OW-1:0] s
);
  // OW = IW + 1 keeps the carry, OW = IW drops it
  assign s = OW'(a) + OW'(b) + OW'(cin);
endmodule

// File: rtl/sx_stage_reg.sv
module sx_stage_reg #(
  parameter int W  = 16,
  parameter int HW = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          transparent,
  input  logic          load,
  input  logic          d_valid,
  input  logic          d_long,
  input  logic [HW-1:0] d_lo,
  input  logic          d_c,
  input  logic [HW-1:0] d_ahi,
  input  logic [HW-1:0] d_bhi,
  input  logic [W-1:0]  d_short,
  output logic          held_valid,
  output logic          q_valid,
  output logic          q_long,
  output logic [HW-1:0] q_lo,
  output logic          q_c,
  output logic [HW-1:0] q_ahi,
  output logic [HW-1:0] q_bhi,
  output logic [W-1:0]  q_short
);
  logic          r_long, r_c;
  logic [HW-1:0] r_lo, r_ahi, r_bhi;
  logic [W-1:0]  r_short;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      r_long     <= 1'b0;
      r_c        <= 1'b0;
      r_lo       <= '0;
      r_ahi      <= '0;
      r_bhi      <= '0;
      r_short    <= '0;
    end else begin
      held_valid <= load;
      if (load) begin
        r_long  <= d_long;
        r_c     <= d_c;
        r_lo    <= d_lo;
        r_ahi   <= d_ahi;
        r_bhi   <= d_bhi;
        r_short <= d_short;
      end
    end
  end

  assign q_valid = transparent ? d_valid : held_valid;
  assign q_long  = transparent ? d_long  : r_long;
  assign q_c     = transparent ? d_c     : r_c;
  assign q_lo    = transparent ? d_lo    : r_lo;
  assign q_ahi   = transparent ? d_ahi   : r_ahi;
  assign q_bhi   = transparent ? d_bhi   : r_bhi;
  assign q_short = transparent ? d_short : r_short;

  // R8: nothing may sit in the register once it runs transparent
  assert_no_hold_when_transparent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid |-> !transparent);
endmodule

// File: rtl/sx_split_exec.sv
module sx_split_exec #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lp_mode_i,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_long,
  input  logic [1:0]   in_func,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int HW = W / 2;

  logic          eff_lp;
  logic          accept;
  logic          held_valid;
  logic          stage_load;
  logic          bypass;
  logic [W-1:0]  short_res;
  logic [HW:0]   lo_full;
  logic [HW-1:0] hi_sum;
  logic          q_valid, q_long, q_c;
  logic [HW-1:0] q_lo, q_ahi, q_bhi;
  logic [W-1:0]  q_short;

  assign in_ready = (lp_mode_i == eff_lp);
  assign accept   = in_valid && in_ready;

  // first half: logic result and low-half sum
  sx_logic_unit #(.W(W)) u_logic (
    .a  (in_a),
    .b  (in_b),
    .fn (sx_pkg::fn_e'(in_func)),
    .y  (short_res)
  );

  sx_add_half #(.IW(HW), .OW(HW + 1)) u_add_lo (
    .a   (in_a[HW-1:0]),
    .b   (in_b[HW-1:0]),
    .cin (1'b0),
    .s   (lo_full)
  );

  // staged when fast: longs always, shorts when something is already staged
  assign stage_load = accept && !eff_lp && (in_long || held_valid);
  assign bypass     = accept && !eff_lp && !held_valid && !in_long;

  sx_stage_reg #(.W(W), .HW(HW)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .transparent (eff_lp),
    .load        (stage_load),
    .d_valid     (accept),
    .d_long      (in_long),
    .d_lo        (lo_full[HW-1:0]),
    .d_c         (lo_full[HW]),
    .d_ahi       (in_a[W-1:HW]),
    .d_bhi       (in_b[W-1:HW]),
    .d_short     (short_res),
    .held_valid  (held_valid),
    .q_valid     (q_valid),
    .q_long      (q_long),
    .q_lo        (q_lo),
    .q_c         (q_c),
    .q_ahi       (q_ahi),
    .q_bhi       (q_bhi),
    .q_short     (q_short)
  );

  // second half: high-half sum with staged carry
  sx_add_half #(.IW(HW), .OW(HW)) u_add_hi (
    .a   (q_ahi),
    .b   (q_bhi),
    .cin (q_c),
    .s   (hi_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_lp    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if ((lp_mode_i != eff_lp) && !held_valid) eff_lp <= lp_mode_i;
      out_valid <= q_valid || bypass;
      if (q_valid)     out_data <= q_long ? {hi_sum, q_lo} : q_short;
      else if (bypass) out_data <= short_res;
    end
  end

  // R4: a staged operation always leaves on the next edge
  assert_staged_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid |=> out_valid);

  // R4: a fast-mode long is staged, not finished, after one edge
  assert_long_staged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !eff_lp && in_long) |=> held_valid);

  // R7: low-power acceptance gives a result on the next cycle
  assert_lp_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && eff_lp) |=> out_valid);

  // R8: the mode only changes when nothing was staged
  assert_switch_when_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eff_lp) |-> !$past(held_valid));

  // R10: no result without an earlier acceptance or staged operation
  assert_no_phantom_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(accept) || $past(held_valid)));
endmodule

// File: tb/tb_sx_split_exec.sv
`timescale 1ns/1ps
module tb_sx_split_exec;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lp_mode_i = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_long = 1'b0;
  logic [1:0]   in_func = 2'd0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  sx_split_exec #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .lp_mode_i(lp_mode_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_long(in_long),
    .in_func(in_func), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  int ntests = 0;
  int nfail  = 0;
  int cyc    = 0;
  int nid    = 0;
  bit done   = 1'b0;
  int lat_of [128];

  logic [W-1:0] exp_val [$];
  int           exp_id  [$];
  int           exp_cyc [$];
  bit           exp_lng [$];

  always @(posedge clk) cyc <= cyc + 1;

  // {long, func, a, b}
  localparam logic [34:0] VEC [0:9] = '{
    {1'b1, 2'd0, 16'h00FF, 16'h0001},
    {1'b0, 2'd0, 16'hF0F0, 16'h3C3C},
    {1'b0, 2'd1, 16'h1200, 16'h0034},
    {1'b1, 2'd0, 16'hFFFF, 16'h0001},
    {1'b0, 2'd2, 16'hAAAA, 16'hFFFF},
    {1'b0, 2'd3, 16'hFFFF, 16'h00F0},
    {1'b1, 2'd0, 16'h7F80, 16'h0080},
    {1'b1, 2'd0, 16'h1234, 16'h4321},
    {1'b0, 2'd0, 16'hFFFF, 16'hABCD},
    {1'b1, 2'd0, 16'h8000, 16'h8000}
  };

  function automatic logic [W-1:0] ref_op(bit lng, logic [1:0] f, logic [W-1:0] a, logic [W-1:0] b);
    if (lng) return a + b;
    case (f)
      2'd0:    return a & b;
      2'd1:    return a | b;
      2'd2:    return a ^ b;
      default: return a & ~b;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // result monitor: values (R2/R3), ordering and counts (R10), latency log
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (exp_val.size() == 0) begin
        ntests++; nfail++;
        $display("FAIL R10 unexpected result: actual %0h expected none", out_data);
      end else begin
        logic [W-1:0] ev;
        int id, c;
        bit lg;
        ev = exp_val.pop_front(); id = exp_id.pop_front();
        c = exp_cyc.pop_front();  lg = exp_lng.pop_front();
        ntests++;
        if (out_data !== ev) begin
          nfail++;
          $display("FAIL %s result of op %0d: actual %0h expected %0h",
                   lg ? "R3" : "R2", id, out_data, ev);
        end
        lat_of[id] = cyc - c;
      end
    end
  end

  task automatic issue(input bit lng, input logic [1:0] f, input logic [W-1:0] a,
                       input logic [W-1:0] b, output int id, output int waits);
    in_valid = 1'b1; in_long = lng; in_func = f; in_a = a; in_b = b;
    waits = 0;
    #1;
    while (!in_ready && waits < 20) begin
      @(negedge clk); #1;
      waits++;
    end
    id = nid++;
    exp_val.push_back(ref_op(lng, f, a, b));
    exp_id.push_back(id);
    exp_cyc.push_back(cyc);
    exp_lng.push_back(lng);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      ntests++; nfail++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int id0, id1, id2, id3, w0, w1, w2, w3, seen;
    for (int i = 0; i < 128; i++) lat_of[i] = -1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    @(negedge clk);

    // table walk, fast mode, back to back (R2, R3, R6, R10)
    for (int i = 0; i < 10; i++) begin
      issue(VEC[i][34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0], id0, w0);
      chk(w0 == 0, "R4", "fast-mode table stall", w0, 0);
    end
    idle(4);

    // R4: single long in fast mode
    issue(1'b1, 2'd0, 16'h0180, 16'h0280, id0, w0);
    idle(4);
    chk(lat_of[id0] == 2, "R4", "long latency fast", lat_of[id0], 2);

    // R5: single short with nothing staged
    issue(1'b0, 2'd2, 16'h0F0F, 16'h00FF, id0, w0);
    idle(4);
    chk(lat_of[id0] == 1, "R5", "short latency fast", lat_of[id0], 1);

    // R4: three longs back to back, no stall
    issue(1'b1, 2'd0, 16'h00FF, 16'h00FF, id0, w0);
    issue(1'b1, 2'd0, 16'h0FFF, 16'h0001, id1, w1);
    issue(1'b1, 2'd0, 16'hFF00, 16'h0100, id2, w2);
    idle(4);
    chk(w1 + w2 == 0, "R4", "long burst stalls", w1 + w2, 0);
    chk(lat_of[id0] == 2 && lat_of[id1] == 2 && lat_of[id2] == 2, "R4",
        "long burst latency", lat_of[id2], 2);

    // R6: long, short, short, gap, short
    issue(1'b1, 2'd0, 16'h1111, 16'h2222, id0, w0);
    issue(1'b0, 2'd1, 16'h0101, 16'h1010, id1, w1);
    issue(1'b0, 2'd0, 16'h3333, 16'h0F0F, id2, w2);
    idle(1);
    issue(1'b0, 2'd3, 16'hFFFF, 16'h1234, id3, w3);
    idle(4);
    chk(w1 + w2 == 0, "R6", "short-after-long stalls", w1 + w2, 0);
    chk(lat_of[id1] == 2, "R6", "short behind long latency", lat_of[id1], 2);
    chk(lat_of[id2] == 2, "R6", "second short in chain latency", lat_of[id2], 2);
    chk(lat_of[id3] == 1, "R5", "short after drain latency", lat_of[id3], 1);

    // R8: request low-power while a long is staged
    issue(1'b1, 2'd0, 16'h4000, 16'h4000, id0, w0);
    lp_mode_i = 1'b1;
    issue(1'b0, 2'd0, 16'hABCD, 16'hFF00, id1, w1);
    idle(4);
    chk(w1 == 2, "R8", "cycles blocked for switch to low-power", w1, 2);
    chk(lat_of[id0] == 2, "R8", "staged long before switch latency", lat_of[id0], 2);
    chk(lat_of[id1] == 1, "R8", "first op after switch latency", lat_of[id1], 1);

    // R7: low-power mode, mixed burst
    issue(1'b1, 2'd0, 16'h00FF, 16'h0001, id0, w0);
    issue(1'b0, 2'd1, 16'h0F00, 16'h00F0, id1, w1);
    issue(1'b1, 2'd0, 16'hFFFF, 16'hFFFF, id2, w2);
    idle(4);
    chk(lat_of[id0] == 1 && lat_of[id2] == 1, "R7", "long latency low-power", lat_of[id2], 1);
    chk(lat_of[id1] == 1, "R7", "short latency low-power", lat_of[id1], 1);

    // table walk, low-power mode
    for (int i = 0; i < 10; i++) begin
      issue(VEC[i][34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0], id0, w0);
      chk(lat_of[id0] == -1 || lat_of[id0] == 1, "R7", "table op latency", lat_of[id0], 1);
    end
    idle(4);
    chk(lat_of[id0] == 1, "R7", "last table op latency low-power", lat_of[id0], 1);

    // R9: offer while blocked by a mode request, then withdraw
    lp_mode_i = 1'b0;
    in_valid = 1'b1; in_long = 1'b0; in_func = 2'd1; in_a = 16'h5A5A; in_b = 16'h0000;
    #1;
    chk(in_ready == 1'b0, "R9", "in_ready during mode request", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    seen = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(seen == 0, "R9", "results from withdrawn offer", seen, 0);
    chk(in_ready == 1'b1, "R8", "in_ready after switch to fast", in_ready, 1);

    // R5 after switch back: fast timing again
    issue(1'b0, 2'd0, 16'hF00F, 16'hFFFF, id0, w0);
    issue(1'b1, 2'd0, 16'h0001, 16'h00FF, id1, w1);
    idle(4);
    chk(lat_of[id0] == 1, "R5", "short after switch to fast", lat_of[id0], 1);
    chk(lat_of[id1] == 2, "R8", "long after switch to fast", lat_of[id1], 2);

    // R10: every accepted op delivered
    chk(exp_val.size() == 0, "R10", "undelivered results", exp_val.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule